// File: doc/BRIEF.md
# Power Mode and Backup Control

This block turns the configuration bits written over the serial port of a battery power manager, together with a few external pins, into the enable signals for the boost converter, its phase-locked clock, the backup regulator, the charger current sources, the two open-drain drivers, the two low-noise regulators and the logic-supply clamp. It is purely digital glue. The analog circuits, the PLL itself and the PWM generator sit outside and consume the enables.

The backup path has the highest priority. It turns on when software asks for it, or by itself when automatic mode is armed and the low-battery comparator trips. While it is on, the converter and every charger current are held off. Run mode needs either the run pin or the run bit. Even then, the PWM is only handed run operation once the PLL reports ready. The asynchronous pins pass through synchronizers, and every output comes from a register. A request from the reset comparator returns all outputs to their power-up state on the next clock.

Top module: `pmc_ctrl`

## Requirements
- R1: Run is requested when `pin_run` or `cfg_run` is high. With both low the block is in coast mode (`pll_en`=0, `pwm_run`=0, `conv_en`=1), and coast is the state after reset.
- R2: `pll_en` is high when run is requested and backup is off. `pwm_run` is additionally gated by `pll_ready`: it is high only if `pll_ready` was high at the preceding clock edge.
- R3: `backup_on` is high when `cfg_backup` is 1, or when `cfg_lbo_auto` is 1 and `pin_lowbat_n` is 0. If `cfg_lbo_auto` is 0, the low-battery pin has no effect.
- R4: While `backup_on` is high, `conv_en`, `pll_en`, `pwm_run`, `chg_hi_en` and `chg_lo_en` are all 0. Drivers and regulator enables are unaffected.
- R5: The charger selection depends on the two charge bits. With `cfg_chg_hi`=1 the high current is chosen, whatever `cfg_chg_lo` is. With only `cfg_chg_lo`=1 the low current is chosen. With neither set the charger is off. `chg_hi_en` and `chg_lo_en` are never both high.
- R6: `drv1_on` follows `cfg_drv1`. `drv2_on` is high only when both `cfg_drv2` and `pin_drv2` are high.
- R7: `clamp_en` is high exactly when bit 4 (the top bit) of the 5-bit `vout_code` is 1, i.e. for codes 16 to 31.
- R8: A cycle with `rst_req` high makes every output take its reset value at the next edge: `conv_en`=1 and every other output 0.
- R9: A change on a `cfg_*`, `vout_code`, `pll_ready` or `rst_req` input shows at the outputs after one clock edge. A change on `pin_run`, `pin_drv2` or `pin_lowbat_n` shows after three edges (two synchronizer stages plus the output register).
- R10: `reg2_en` follows `cfg_reg2` and `reg3_en` follows `cfg_reg3`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_run | input | 1 | Run/coast register bit |
| cfg_backup | input | 1 | Manual backup-enable bit |
| cfg_lbo_auto | input | 1 | Arms automatic backup on low battery |
| cfg_chg_hi | input | 1 | High charge current request |
| cfg_chg_lo | input | 1 | Low charge current request |
| cfg_drv1 | input | 1 | Driver 1 enable bit |
| cfg_drv2 | input | 1 | Driver 2 gate bit |
| cfg_reg2 | input | 1 | Analog regulator enable bit |
| cfg_reg3 | input | 1 | Receiver regulator enable bit |
| vout_code | input | 5 | Output-voltage code; bit 4 arms the clamp |
| pin_run | input | 1 | Asynchronous run pin |
| pin_drv2 | input | 1 | Asynchronous driver 2 gating input (e.g. tone clock) |
| pin_lowbat_n | input | 1 | Asynchronous low-battery comparator, active low |
| pll_ready | input | 1 | PLL locked / free-run ready, synchronous |
| rst_req | input | 1 | Reset-comparator request, synchronous, active high |
| conv_en | output | 1 | Boost converter enabled |
| pll_en | output | 1 | Sync/PLL and PWM control powered (run mode) |
| pwm_run | output | 1 | PWM granted fixed-frequency run operation |
| backup_on | output | 1 | Backup regulator enabled |
| chg_hi_en | output | 1 | High charge current source on |
| chg_lo_en | output | 1 | Low charge current source on |
| drv1_on | output | 1 | Open-drain driver 1 gate |
| drv2_on | output | 1 | Open-drain driver 2 gate |
| reg2_en | output | 1 | Analog regulator enable |
| reg3_en | output | 1 | Receiver regulator enable |
| clamp_en | output | 1 | Logic-supply clamp enable |

## Verification
Run selection is tried from the bit alone and from the pin alone, each with and without PLL ready. This separates the OR of the two sources from the lock gating. Backup is raised by the manual bit, by automatic mode with the pin low, by the pin low without automatic mode, and by automatic mode with the pin high. Only the first two may switch the converter and charger off. Each charge-bit combination is applied, and the driver 2 gate is toggled from each side, which shows the priority encoding and the AND. Directed steps count the edges a pin change needs against a register change, and pulse the reset request over a busy configuration.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

  typedef struct packed {
    logic conv_en;
    logic pll_en;
    logic pwm_run;
    logic backup_on;
    logic chg_hi;
    logic chg_lo;
    logic drv1;
    logic drv2;
    logic reg2;
    logic reg3;
    logic clamp;
  } pmc_ctl_t;

  typedef struct packed {
    logic run;
    logic backup;
    logic lbo_auto;
    logic chg_hi;
    logic chg_lo;
    logic drv1;
    logic drv2;
    logic reg2;
    logic reg3;
  } pmc_cfg_t;

  typedef enum logic [1:0] {
    CHG_OFF  = 2'b00,
    CHG_LOW  = 2'b01,
    CHG_HIGH = 2'b10
  } chg_sel_e;

  // Power-up state: converter alive in coast, everything else off.
  localparam pmc_ctl_t CTL_RESET = '{conv_en: 1'b1, default: 1'b0};

  function automatic logic want_run(input logic bit_run, input logic pin_run);
    return bit_run | pin_run;
  endfunction

  function automatic logic want_backup(input logic bit_bk, input logic auto_arm,
                                       input logic lowbat_n);
    return bit_bk | (auto_arm & ~lowbat_n);
  endfunction

  function automatic chg_sel_e pick_charge(input logic hi, input logic lo,
                                           input logic bk);
    if (bk)      return CHG_OFF;
    else if (hi) return CHG_HIGH;
    else if (lo) return CHG_LOW;
    else         return CHG_OFF;
  endfunction

endpackage

// File: rtl/pmc_sync.sv
module pmc_sync #(
  parameter int unsigned WIDTH   = 3,
  parameter int unsigned STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  generate
    if (STAGES <= 1) begin : g_single
      logic [WIDTH-1:0] stg;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg <= RST_VAL;
        else        stg <= d;
      end
      assign q = stg;
    end else begin : g_chain
      logic [STAGES-1:0][WIDTH-1:0] stg;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg <= {STAGES{RST_VAL}};
        else        stg <= {stg[STAGES-2:0], d};
      end
      assign q = stg[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/pmc_decode.sv
module pmc_decode
  import pmc_pkg::*;
#(
  parameter int unsigned OV_W = 5
) (
  input  pmc_cfg_t        cfg,
  input  logic [OV_W-1:0] vout_code,
  input  logic            run_pin_s,
  input  logic            drv2_pin_s,
  input  logic            lowbat_n_s,
  input  logic            pll_ready,
  input  logic            rst_req,
  output logic            run_req,
  output logic            bk_req,
  output pmc_ctl_t        nxt
);

  localparam logic [OV_W-1:0] CLAMP_CODE = OV_W'(1) << (OV_W - 1);

  chg_sel_e chg;

  assign run_req = want_run(cfg.run, run_pin_s);
  assign bk_req  = want_backup(cfg.backup, cfg.lbo_auto, lowbat_n_s);
  assign chg     = pick_charge(cfg.chg_hi, cfg.chg_lo, bk_req);

  always_comb begin
    if (rst_req) begin
      nxt = CTL_RESET;
    end else begin
      nxt.conv_en   = ~bk_req;
      nxt.pll_en    = run_req & ~bk_req;
      nxt.pwm_run   = run_req & ~bk_req & pll_ready;
      nxt.backup_on = bk_req;
      nxt.chg_hi    = (chg == CHG_HIGH);
      nxt.chg_lo    = (chg == CHG_LOW);
      nxt.drv1      = cfg.drv1;
      nxt.drv2      = cfg.drv2 & drv2_pin_s;
      nxt.reg2      = cfg.reg2;
      nxt.reg3      = cfg.reg3;
      nxt.clamp     = (vout_code >= CLAMP_CODE);
    end
  end

endmodule

// File: rtl/pmc_ctrl.sv
module pmc_ctrl
  import pmc_pkg::*;
#(
  parameter int unsigned OV_W        = 5,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_run,
  input  logic            cfg_backup,
  input  logic            cfg_lbo_auto,
  input  logic            cfg_chg_hi,
  input  logic            cfg_chg_lo,
  input  logic            cfg_drv1,
  input  logic            cfg_drv2,
  input  logic            cfg_reg2,
  input  logic            cfg_reg3,
  input  logic [OV_W-1:0] vout_code,
  input  logic            pin_run,
  input  logic            pin_drv2,
  input  logic            pin_lowbat_n,
  input  logic            pll_ready,
  input  logic            rst_req,
  output logic            conv_en,
  output logic            pll_en,
  output logic            pwm_run,
  output logic            backup_on,
  output logic            chg_hi_en,
  output logic            chg_lo_en,
  output logic            drv1_on,
  output logic            drv2_on,
  output logic            reg2_en,
  output logic            reg3_en,
  output logic            clamp_en
);

  localparam int unsigned NPIN = 3;
  localparam logic [NPIN-1:0] PIN_IDLE = 3'b001;  // {run, drv2, lowbat_n}

  pmc_cfg_t        cfg;
  logic [NPIN-1:0] pins_s;
  logic            run_pin_s, drv2_pin_s, lowbat_n_s;
  logic            run_req, bk_req;
  pmc_ctl_t        ctl_d, ctl_q;

  assign cfg = '{run: cfg_run, backup: cfg_backup, lbo_auto: cfg_lbo_auto,
                 chg_hi: cfg_chg_hi, chg_lo: cfg_chg_lo, drv1: cfg_drv1,
                 drv2: cfg_drv2, reg2: cfg_reg2, reg3: cfg_reg3};

  pmc_sync #(.WIDTH(NPIN), .STAGES(SYNC_STAGES), .RST_VAL(PIN_IDLE)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({pin_run, pin_drv2, pin_lowbat_n}),
    .q     (pins_s)
  );

  assign {run_pin_s, drv2_pin_s, lowbat_n_s} = pins_s;

  pmc_decode #(.OV_W(OV_W)) u_dec (
    .cfg        (cfg),
    .vout_code  (vout_code),
    .run_pin_s  (run_pin_s),
    .drv2_pin_s (drv2_pin_s),
    .lowbat_n_s (lowbat_n_s),
    .pll_ready  (pll_ready),
    .rst_req    (rst_req),
    .run_req    (run_req),
    .bk_req     (bk_req),
    .nxt        (ctl_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_q <= CTL_RESET;
    else        ctl_q <= ctl_d;
  end

  assign conv_en   = ctl_q.conv_en;
  assign pll_en    = ctl_q.pll_en;
  assign pwm_run   = ctl_q.pwm_run;
  assign backup_on = ctl_q.backup_on;
  assign chg_hi_en = ctl_q.chg_hi;
  assign chg_lo_en = ctl_q.chg_lo;
  assign drv1_on   = ctl_q.drv1;
  assign drv2_on   = ctl_q.drv2;
  assign reg2_en   = ctl_q.reg2;
  assign reg3_en   = ctl_q.reg3;
  assign clamp_en  = ctl_q.clamp;

  // Assertions guarding the registered enables

  p_coast_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(cfg_run) && !$past(run_pin_s)) |-> (!pll_en && !pwm_run));

  p_lock_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pwm_run |-> ($past(pll_ready) && pll_en));

  p_auto_backup_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(bk_req) && !$past(rst_req)) |-> backup_on);

  p_backup_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    backup_on |-> (!conv_en && !pll_en && !chg_hi_en && !chg_lo_en));

  p_chg_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({chg_hi_en, chg_lo_en}));

  p_drv2_and_r6: assert property (@(posedge clk) disable iff (!rst_n)
    drv2_on |-> ($past(cfg_drv2) && $past(drv2_pin_s)));

  p_clamp_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clamp_en |-> $past(vout_code[OV_W-1]));

  p_rst_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> (conv_en && !pll_en && !pwm_run && !backup_on && !chg_hi_en &&
                 !chg_lo_en && !drv1_on && !drv2_on && !reg2_en && !reg3_en &&
                 !clamp_en));

endmodule

// File: tb/pmc_ctrl_test.sv
`timescale 1ns/1ps
module pmc_ctrl_test;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_run, cfg_backup, cfg_lbo_auto, cfg_chg_hi, cfg_chg_lo;
  logic cfg_drv1, cfg_drv2, cfg_reg2, cfg_reg3;
  logic [4:0] vout_code;
  logic pin_run, pin_drv2, pin_lowbat_n, pll_ready, rst_req;
  logic conv_en, pll_en, pwm_run, backup_on, chg_hi_en, chg_lo_en;
  logic drv1_on, drv2_on, reg2_en, reg3_en, clamp_en;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;  // 200 MHz

  pmc_ctrl uut (
    .clk(clk), .rst_n(rst_n),
    .cfg_run(cfg_run), .cfg_backup(cfg_backup), .cfg_lbo_auto(cfg_lbo_auto),
    .cfg_chg_hi(cfg_chg_hi), .cfg_chg_lo(cfg_chg_lo), .cfg_drv1(cfg_drv1),
    .cfg_drv2(cfg_drv2), .cfg_reg2(cfg_reg2), .cfg_reg3(cfg_reg3),
    .vout_code(vout_code), .pin_run(pin_run), .pin_drv2(pin_drv2),
    .pin_lowbat_n(pin_lowbat_n), .pll_ready(pll_ready), .rst_req(rst_req),
    .conv_en(conv_en), .pll_en(pll_en), .pwm_run(pwm_run), .backup_on(backup_on),
    .chg_hi_en(chg_hi_en), .chg_lo_en(chg_lo_en), .drv1_on(drv1_on),
    .drv2_on(drv2_on), .reg2_en(reg2_en), .reg3_en(reg3_en), .clamp_en(clamp_en)
  );

  // Observed outputs: conv pll pwm bk hi lo d1 d2 r2 r3 clamp
  wire [10:0] obs = {conv_en, pll_en, pwm_run, backup_on, chg_hi_en, chg_lo_en,
                     drv1_on, drv2_on, reg2_en, reg3_en, clamp_en};
  localparam logic [10:0] OBS_RESET = 11'b10000000000;

  // Vector: [32:29] requirement, [28:20] rb bk au hi lo d1 d2 r2 r3,
  //         [19:15] vout_code, [14:11] run_pin drv2_pin lowbat_n pll_ready,
  //         [10:0] expected outputs.
  localparam int NV = 17;
  localparam logic [32:0] VEC [NV] = '{
    {4'd1,  9'b000000000, 5'b00000, 4'b0010, 11'b10000000000}, // R1 coast
    {4'd2,  9'b100000000, 5'b00000, 4'b0010, 11'b11000000000}, // R2 no lock
    {4'd2,  9'b100000000, 5'b00000, 4'b0011, 11'b11100000000}, // R2 locked
    {4'd1,  9'b000000000, 5'b00000, 4'b1011, 11'b11100000000}, // R1 pin run
    {4'd5,  9'b000110000, 5'b00000, 4'b0010, 11'b10001000000}, // R5 both
    {4'd5,  9'b000010000, 5'b00000, 4'b0010, 11'b10000100000}, // R5 low
    {4'd5,  9'b000100000, 5'b00000, 4'b0010, 11'b10001000000}, // R5 high
    {4'd4,  9'b110100000, 5'b00000, 4'b0011, 11'b00010000000}, // R4 manual
    {4'd3,  9'b001010000, 5'b00000, 4'b0000, 11'b00010000000}, // R3 auto low
    {4'd3,  9'b001010000, 5'b00000, 4'b0010, 11'b10000100000}, // R3 auto ok
    {4'd3,  9'b000010000, 5'b00000, 4'b0000, 11'b10000100000}, // R3 disarmed
    {4'd6,  9'b000001100, 5'b00000, 4'b0010, 11'b10000010000}, // R6 pin low
    {4'd6,  9'b000000100, 5'b00000, 4'b0110, 11'b10000001000}, // R6 both
    {4'd6,  9'b000000000, 5'b00000, 4'b0110, 11'b10000000000}, // R6 bit low
    {4'd10, 9'b000000010, 5'b10000, 4'b0010, 11'b10000000101}, // R10 reg2 + clamp
    {4'd7,  9'b000000001, 5'b01111, 4'b0010, 11'b10000000010}, // R7 code 15
    {4'd4,  9'b010001010, 5'b00000, 4'b0010, 11'b00010010100}  // R4 drivers kept
  };

  task automatic chk(input int req, input logic [10:0] got, input logic [10:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL R%0d got=%b expected=%b", req, got, exp);
    end
  endtask

  task automatic apply(input logic [28:11] v);
    {cfg_run, cfg_backup, cfg_lbo_auto, cfg_chg_hi, cfg_chg_lo,
     cfg_drv1, cfg_drv2, cfg_reg2, cfg_reg3} = v[28:20];
    vout_code = v[19:15];
    {pin_run, pin_drv2, pin_lowbat_n, pll_ready} = v[14:11];
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    apply('0);
    pin_lowbat_n = 1'b1;
    rst_req = 1'b0;
    repeat (3) @(negedge clk);
    chk(1, obs, OBS_RESET);  // R1 / R8 reset values while held
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(1, obs, OBS_RESET);  // R1 coast after reset

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      apply(VEC[i][28:11]);
      repeat (4) @(negedge clk);
      chk(int'(VEC[i][32:29]), obs, VEC[i][10:0]);
    end

    // R9: pin path needs three edges
    @(negedge clk);
    apply({9'b0, 5'b0, 4'b0011});
    repeat (4) @(negedge clk);
    pin_run = 1'b1;
    repeat (2) @(negedge clk);
    chk(9, {8'b0, pwm_run, pll_en, conv_en}, 11'b00000000001);
    @(negedge clk);
    chk(9, {8'b0, pwm_run, pll_en, conv_en}, 11'b00000000111);

    // R2: losing lock drops pwm_run after one edge, pll_en stays
    pll_ready = 1'b0;
    @(negedge clk);
    chk(2, {9'b0, pwm_run, pll_en}, 11'b00000000001);

    // R9: register path needs one edge
    cfg_drv1 = 1'b1;
    @(negedge clk);
    chk(9, {10'b0, drv1_on}, 11'b1);

    // R9 / R3: low-battery pin with auto mode, three edges
    cfg_lbo_auto = 1'b1;
    pin_lowbat_n = 1'b0;
    repeat (2) @(negedge clk);
    chk(9, {10'b0, backup_on}, 11'b0);
    @(negedge clk);
    chk(3, {9'b0, backup_on, conv_en}, 11'b10);
    pin_lowbat_n = 1'b1;
    cfg_lbo_auto = 1'b0;
    repeat (4) @(negedge clk);

    // R8: one-cycle reset request over a busy configuration
    cfg_run = 1'b1; cfg_chg_hi = 1'b1; cfg_reg2 = 1'b1; cfg_reg3 = 1'b1;
    vout_code = 5'b11000; pll_ready = 1'b1;
    repeat (2) @(negedge clk);
    chk(8, obs, 11'b11101010111);
    rst_req = 1'b1;
    @(negedge clk);
    rst_req = 1'b0;
    chk(8, obs, OBS_RESET);
    @(negedge clk);
    chk(8, obs, 11'b11101010111);

    // R1: both run sources low returns to coast
    cfg_run = 1'b0; pin_run = 1'b0;
    repeat (4) @(negedge clk);
    chk(1, {8'b0, conv_en, pll_en, pwm_run}, 11'b100);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule